// File: doc/BRIEF.md
# Configuration Command Controller

This block is a register-triggered command engine for board configuration. Software sees three registers: a data register, a control register and a status register. Writing the control register with the start bit set runs one command. The command's fields are decoded from the word being written. The command then reads or writes an entry of an internal oscillator-frequency table, returns a fixed sensor value, or raises a shutdown or reboot request.

Each command completes at the clock edge that accepts the triggering write. The status register then shows completion, and error when the target is unsupported. A successful read leaves its result in the data register. A write command takes its operand from the data register as it stood before the command.

The register port is a plain synchronous write strobe with a two-bit register address and a combinational read path. The register map is: address 0 is data, address 1 is control, address 2 is status, and address 3 reads as zero and ignores writes. Within the control word, start is at bit 31 and write is at bit 30. The controller number is at [29:26], the function at [25:20], the site at [17:16], the position at [15:12] and the device at [11:0].

Top module: `cfgcmd_ctrl`

## Requirements
- R1: After a synchronous active-low reset, data, control and status read as 0. The six main-board clock entries hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000. Each daughter-board clock entry holds its parameter reset value.
- R2: A control write stores the word with bits 31, 19 and 18 forced to zero on readback.
- R3: Every control write with bit 31 set sets status bit 0. Status bit 1 is set exactly when the command is unsupported, and is cleared otherwise.
- R4: A command is unsupported unless the controller number is 0, the position is 0, and the site is 0 (main board) or 1 (daughter board).
- R5: A read of function 1 (oscillator) returns main-board entry `device` for site 0 when device < 6. For site 1 it returns daughter-board entry `device` when device < DB_CLKS. Any other device is an error.
- R6: A write of function 1 stores the current data register value into the addressed entry. An out-of-range device is an error and changes no entry.
- R7: A read of function 2 (voltage) returns 3300000 for site 0, device 0. For site 1 with device < DB_VSENS it returns that sensor's parameter value. Every other voltage access, including any write, is an error.
- R8: A successful read command loads its result into the data register. A failed read and any write command leave the data register unchanged.
- R9: A write of function 8 or function 9 at site 0, device 0 raises a one-cycle shutdown or reboot request, respectively, in the cycle after the accepting edge. Any other form of these commands is an error and raises no request.
- R10: A write of function 7 or function 11 at site 0, device 0 succeeds with no effect. Reads of these functions, and every other function code, are errors.
- R11: A direct status write keeps only bits 1:0; the upper bits read as zero.
- R12: A control write with bit 31 clear runs no command and leaves status, data and the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 data, 1 control, 2 status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
The bench sweeps every function code against every site and the first eight device indices. This covers both table bounds: a design comparing with <= instead of < would accept device 6 on the main board or device DB_CLKS on the daughter board, where it should report an error. Nonzero controller and position fields are also swept, so a decoder that ignores them returns data where it should flag an error. Before each command the data register is seeded with a marker, which catches a failed read that still overwrites data or a write command that loads a result. The request outputs are checked for exactly one cycle of assertion, and for silence on reads and wrong devices. Sticky error bits and control bits that are not cleared are caught on readback.

// File: rtl/cfgcmd_pkg.sv
// Package: shared constants and helpers for the configuration command engine.
// Assumes a 32-bit register word and a fixed six-entry main-board clock bank.
package cfgcmd_pkg;

    localparam int WORD_W    = 32;
    localparam int MAIN_OSC  = 6;

    // Register addresses
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    // Function codes
    localparam logic [5:0] FN_OSC    = 6'd1;
    localparam logic [5:0] FN_VOLT   = 6'd2;
    localparam logic [5:0] FN_VIDSEL = 6'd7;
    localparam logic [5:0] FN_HALT   = 6'd8;
    localparam logic [5:0] FN_RESTART= 6'd9;
    localparam logic [5:0] FN_DISPMD = 6'd11;

    localparam logic [31:0] MAIN_VOLT_UV = 32'd3300000;

    // Bits that are stored from a control write (31, 19, 18 dropped)
    localparam logic [31:0] CTRL_KEEP = ~((32'h3 << 18) | (32'h1 << 31));

    typedef struct packed {
        logic        start;
        logic        write;
        logic [3:0]  ctl_num;
        logic [5:0]  func;
        logic [1:0]  rsvd;
        logic [1:0]  site;
        logic [3:0]  pos;
        logic [11:0] dev;
    } cmd_word_t;

    // Reset frequency of main-board clock entry i
    function automatic logic [31:0] main_osc_reset(input int i);
        if (i == 0)      return 32'd50000000;
        else if (i == 1) return 32'd23750000;
        else             return 32'd24000000;
    endfunction

endpackage

// File: rtl/cfgcmd_decode.sv
// Module: combinational command decoder. Classifies a control word as
// supported or not and says which action it requests.
// Assumes device indices beyond the table sizes are errors.
module cfgcmd_decode
    import cfgcmd_pkg::*;
#(
    parameter int                   DB_CLKS   = 2,
    parameter int                   DB_VSENS  = 2,
    parameter logic [DB_VSENS*32-1:0] DB_VOLT = '0,
    localparam int                  N_OSC     = MAIN_OSC + DB_CLKS,
    localparam int                  IDX_W     = $clog2(N_OSC)
) (
    input  logic [31:0]      cmd_i,
    output logic             ok_o,
    output logic             tbl_sel_o,
    output logic             tbl_we_o,
    output logic [IDX_W-1:0] tbl_idx_o,
    output logic [31:0]      const_o,
    output logic             halt_o,
    output logic             restart_o
);

    cmd_word_t c;
    logic base_ok, on_main, on_db, dev0;

    assign c       = cmd_word_t'(cmd_i);
    assign base_ok = (c.ctl_num == 4'd0) && (c.pos == 4'd0) && (c.site[1] == 1'b0);
    assign on_main = (c.site == 2'd0);
    assign on_db   = (c.site == 2'd1);
    assign dev0    = (c.dev == 12'd0);

    // Classify the command and select its target.
    always_comb begin
        ok_o      = 1'b0;
        tbl_sel_o = 1'b0;
        tbl_we_o  = 1'b0;
        tbl_idx_o = '0;
        const_o   = '0;
        halt_o    = 1'b0;
        restart_o = 1'b0;
        if (base_ok) begin
            unique case (c.func)
                FN_OSC: begin
                    for (int i = 0; i < MAIN_OSC; i++) begin
                        if (on_main && c.dev == 12'(i)) begin
                            ok_o      = 1'b1;
                            tbl_idx_o = IDX_W'(i);
                        end
                    end
                    for (int i = 0; i < DB_CLKS; i++) begin
                        if (on_db && c.dev == 12'(i)) begin
                            ok_o      = 1'b1;
                            tbl_idx_o = IDX_W'(MAIN_OSC + i);
                        end
                    end
                    tbl_sel_o = ok_o;
                    tbl_we_o  = ok_o && c.write;
                end
                FN_VOLT: begin
                    if (!c.write) begin
                        if (on_main && dev0) begin
                            ok_o    = 1'b1;
                            const_o = MAIN_VOLT_UV;
                        end
                        for (int i = 0; i < DB_VSENS; i++) begin
                            if (on_db && c.dev == 12'(i)) begin
                                ok_o    = 1'b1;
                                const_o = DB_VOLT[i*32 +: 32];
                            end
                        end
                    end
                end
                FN_VIDSEL, FN_DISPMD: ok_o = c.write && on_main && dev0;
                FN_HALT: begin
                    ok_o   = c.write && on_main && dev0;
                    halt_o = ok_o;
                end
                FN_RESTART: begin
                    ok_o      = c.write && on_main && dev0;
                    restart_o = ok_o;
                end
                default: ok_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/cfgcmd_osc_table.sv
// Module: oscillator frequency table, main-board entries first, then
// daughter-board entries. One write port and one combinational read port.
// Assumes the write index is always in range (the decoder guarantees it).
module cfgcmd_osc_table
    import cfgcmd_pkg::*;
#(
    parameter int                     DB_CLKS  = 2,
    parameter logic [DB_CLKS*32-1:0]  DB_INIT  = '0,
    localparam int                    N_OSC    = MAIN_OSC + DB_CLKS,
    localparam int                    IDX_W    = $clog2(N_OSC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o
);

    logic [31:0] ent [N_OSC];

    for (genvar g = 0; g < N_OSC; g++) begin : g_ent
        localparam logic [31:0] RST_V = (g < MAIN_OSC) ? main_osc_reset(g)
                                                       : DB_INIT[(g-MAIN_OSC)*32 +: 32];
        // Hold one entry: reset value, or written value when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= RST_V;
            else if (we_i && idx_i == IDX_W'(g))
                ent[g] <= wdata_i;
        end
    end

    // Read the addressed entry.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N_OSC; i++)
            if (idx_i == IDX_W'(i)) rdata_o = ent[i];
    end

endmodule

// File: rtl/cfgcmd_ctrl.sv
// Module: top of the configuration command engine. Holds the data, control
// and status registers, launches a command on a control write with the
// start bit, and emits one-cycle shutdown and reboot requests.
// Assumes the register master issues at most one write per cycle.
module cfgcmd_ctrl
    import cfgcmd_pkg::*;
#(
    parameter int                      DB_CLKS   = 2,
    parameter int                      DB_VSENS  = 2,
    parameter logic [DB_CLKS*32-1:0]   DB_CLK_INIT  = {32'd45000000, 32'd60000000},
    parameter logic [DB_VSENS*32-1:0]  DB_VOLT_INIT = {32'd1100000, 32'd900000},
    localparam int                     N_OSC = MAIN_OSC + DB_CLKS,
    localparam int                     IDX_W = $clog2(N_OSC)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        shutdown_req,
    output logic        reboot_req
);

    logic [31:0]      data_q, ctrl_q, tbl_rd;
    logic [1:0]       status_q;
    logic             dec_ok, dec_sel, dec_we, dec_halt, dec_restart;
    logic [IDX_W-1:0] dec_idx;
    logic [31:0]      dec_const;
    logic             launch;

    assign launch = reg_wr && (reg_addr == A_CTRL) && reg_wdata[31];

    cfgcmd_decode #(
        .DB_CLKS (DB_CLKS),
        .DB_VSENS(DB_VSENS),
        .DB_VOLT (DB_VOLT_INIT)
    ) dec_i (
        .cmd_i    (reg_wdata),
        .ok_o     (dec_ok),
        .tbl_sel_o(dec_sel),
        .tbl_we_o (dec_we),
        .tbl_idx_o(dec_idx),
        .const_o  (dec_const),
        .halt_o   (dec_halt),
        .restart_o(dec_restart)
    );

    cfgcmd_osc_table #(
        .DB_CLKS(DB_CLKS),
        .DB_INIT(DB_CLK_INIT)
    ) tbl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (launch && dec_we),
        .idx_i  (dec_idx),
        .wdata_i(data_q),
        .rdata_o(tbl_rd)
    );

    // Register writes and command completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            ctrl_q   <= '0;
            status_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_DATA: data_q <= reg_wdata;
                A_CTRL: begin
                    ctrl_q <= reg_wdata & CTRL_KEEP;
                    if (reg_wdata[31]) begin
                        status_q <= {~dec_ok, 1'b1};
                        if (dec_ok && !reg_wdata[30])
                            data_q <= dec_sel ? tbl_rd : dec_const;
                    end
                end
                A_STAT: status_q <= reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    // One-cycle request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown_req <= 1'b0;
            reboot_req   <= 1'b0;
        end else begin
            shutdown_req <= launch && dec_halt;
            reboot_req   <= launch && dec_restart;
        end
    end

    // Read mux.
    always_comb begin
        unique case (reg_addr)
            A_DATA:  reg_rdata = data_q;
            A_CTRL:  reg_rdata = ctrl_q;
            A_STAT:  reg_rdata = {30'd0, status_q};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfgcmd_ctrl_chk.sv
// Module: assertion checker for cfgcmd_ctrl, attached by bind.
module cfgcmd_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [31:0] data_q,
    input logic [1:0]  status_q,
    input logic        shutdown_req,
    input logic        reboot_req
);

    assert_ctrl_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1) |-> (reg_rdata[31] == 1'b0 && reg_rdata[19:18] == 2'b00));

    assert_done_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && reg_wdata[31]) |=> status_q[0]);

    assert_data_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == 2'd0 || reg_addr == 2'd1)) |=> $stable(data_q));

    assert_halt_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(reg_wr && reg_addr == 2'd1 && reg_wdata[31] && reg_wdata[30]));

    assert_restart_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |-> $past(reg_wr && reg_addr == 2'd1 && reg_wdata[31] && reg_wdata[30]));

    assert_req_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(shutdown_req && reboot_req));

    assert_stat_upper_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd2) |-> (reg_rdata[31:2] == 30'd0));

    assert_no_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && !reg_wdata[31]) |=> $stable(status_q));

endmodule

bind cfgcmd_ctrl cfgcmd_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .data_q      (data_q),
    .status_q    (status_q),
    .shutdown_req(shutdown_req),
    .reboot_req  (reboot_req)
);

// File: tb/cfgcmd_ctrl_tb_top.sv
// Bench: sweeps commands over the default configuration and compares every
// status, data and request outcome with a model computed here.
module cfgcmd_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        shutdown_req, reboot_req;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [31:0] mb_m [6];
    logic [31:0] db_m [2];
    logic [31:0] dbv_m [2];

    always #5 clk = ~clk;

    cfgcmd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .shutdown_req(shutdown_req), .reboot_req(reboot_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one register; returns at the following falling edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    function automatic logic [31:0] mk(input bit w, input int dcc, input int fn,
                                       input int site, input int pos, input int dev);
        return {1'b1, w, 4'(dcc), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
    endfunction

    // Expected outcome of a command.
    function automatic bit model_ok(input bit w, input int dcc, input int fn,
                                    input int site, input int pos, input int dev,
                                    output logic [31:0] v);
        v = '0;
        if (dcc != 0 || pos != 0 || site > 1) return 1'b0;
        case (fn)
            1: begin
                if (site == 0 && dev < 6) begin v = mb_m[dev]; return 1'b1; end
                if (site == 1 && dev < 2) begin v = db_m[dev]; return 1'b1; end
                return 1'b0;
            end
            2: begin
                if (w) return 1'b0;
                if (site == 0 && dev == 0) begin v = 32'd3300000; return 1'b1; end
                if (site == 1 && dev < 2) begin v = dbv_m[dev]; return 1'b1; end
                return 1'b0;
            end
            7, 8, 9, 11: return w && site == 0 && dev == 0;
            default: return 1'b0;
        endcase
    endfunction

    // Run one command with a seeded data register and check all outcomes.
    task automatic run_cmd(input bit w, input int dcc, input int fn, input int site,
                           input int pos, input int dev, input logic [31:0] seed);
        logic [31:0] v, got;
        bit ok;
        bit exp_sd, exp_rb;
        ok = model_ok(w, dcc, fn, site, pos, dev, v);
        exp_sd = ok && fn == 8;
        exp_rb = ok && fn == 9;
        wr(2'd0, seed);
        wr(2'd1, mk(w, dcc, fn, site, pos, dev));
        check("R9 shutdown pulse", {31'd0, shutdown_req}, {31'd0, exp_sd});
        check("R9 reboot pulse", {31'd0, reboot_req}, {31'd0, exp_rb});
        rd(2'd2, got);
        check("R3 R4 status", got, ok ? 32'd1 : 32'd3);
        rd(2'd0, got);
        check("R8 data", got, (ok && !w) ? v : seed);
        if (ok && w && fn == 1) begin
            if (site == 0) mb_m[dev] = seed; else db_m[dev] = seed;
        end
        @(negedge clk);
        check("R9 pulse ends", {30'd0, shutdown_req, reboot_req}, 32'd0);
    endtask

    initial begin
        logic [31:0] got;
        for (int i = 0; i < 6; i++) mb_m[i] = (i == 0) ? 32'd50000000 : (i == 1) ? 32'd23750000 : 32'd24000000;
        db_m[0] = 32'd60000000; db_m[1] = 32'd45000000;
        dbv_m[0] = 32'd900000;  dbv_m[1] = 32'd1100000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of registers
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), got);
            check("R1 reset reg", got, 32'd0);
        end
        check("R1 no requests", {30'd0, shutdown_req, reboot_req}, 32'd0);

        // R1 R5 R7 R10 R4: read sweep, also shows reset table contents
        for (int fn = 0; fn < 16; fn++)
            for (int site = 0; site < 4; site++)
                for (int dev = 0; dev < 8; dev++)
                    run_cmd(1'b0, 0, fn, site, 0, dev, 32'hA5000000 | 32'(fn*256 + site*16 + dev));

        // R4: nonzero controller number or position
        for (int k = 1; k < 4; k++) begin
            run_cmd(1'b0, k, 1, 0, 0, 0, 32'h11110000 + 32'(k));
            run_cmd(1'b0, 0, 1, 0, k, 0, 32'h22220000 + 32'(k));
            run_cmd(1'b1, k, 8, 0, 0, 0, 32'h33330000 + 32'(k));
        end

        // R6 R7 R9 R10: write sweep, then read back the table
        for (int fn = 0; fn < 16; fn++)
            for (int site = 0; site < 3; site++)
                for (int dev = 0; dev < 8; dev++)
                    run_cmd(1'b1, 0, fn, site, 0, dev, 32'h5A000000 | 32'(fn*256 + site*16 + dev));
        for (int site = 0; site < 2; site++)
            for (int dev = 0; dev < 7; dev++)
                run_cmd(1'b0, 0, 1, site, 0, dev, 32'hC0DE0000 + 32'(dev));

        // R2 R12: control write without start
        wr(2'd2, 32'd2);
        wr(2'd0, 32'h0BADCAFE);
        wr(2'd1, 32'h7FFF_FFFF);
        rd(2'd1, got);
        check("R2 ctrl readback", got, 32'h7FF3_FFFF);
        rd(2'd2, got);
        check("R12 status held", got, 32'd2);
        rd(2'd0, got);
        check("R12 data held", got, 32'h0BADCAFE);
        check("R12 no request", {30'd0, shutdown_req, reboot_req}, 32'd0);

        // R2: start bit reads zero after a command
        wr(2'd1, mk(1'b0, 0, 1, 0, 0, 2));
        rd(2'd1, got);
        check("R2 start cleared", got, mk(1'b0, 0, 1, 0, 0, 2) & 32'h7FFF_FFFF);

        // R11: direct status writes
        for (int v = 0; v < 8; v++) begin
            wr(2'd2, 32'hFFFF_FFF8 | 32'(v));
            rd(2'd2, got);
            check("R11 status write", got, 32'(v & 3));
        end

        // R3: error clears on a following good command
        run_cmd(1'b0, 0, 5, 0, 0, 0, 32'h1);
        run_cmd(1'b0, 0, 2, 0, 0, 0, 32'h2);

        // R9: back-to-back shutdown then reboot
        wr(2'd1, mk(1'b1, 0, 8, 0, 0, 0));
        check("R9 shutdown first", {30'd0, shutdown_req, reboot_req}, 32'd2);
        wr(2'd1, mk(1'b1, 0, 9, 0, 0, 0));
        check("R9 reboot second", {30'd0, shutdown_req, reboot_req}, 32'd1);
        @(negedge clk);
        check("R9 both idle", {30'd0, shutdown_req, reboot_req}, 32'd0);

        // Unmapped address reads zero
        wr(2'd3, 32'hFFFFFFFF);
        rd(2'd3, got);
        check("R1 unmapped zero", got, 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule